// File: doc/BRIEF.md
# Palette Memory Host Port

This block holds a palette of 512 color words, each 9 bits wide, and gives a host CPU byte-wide access to it through eight register selects. The host first loads a 9-bit color pointer in two byte writes. It then moves color words in and out in two steps: the low byte and then the single upper bit. Only the upper-bit step advances the pointer, so a run of low/high pairs walks through the palette one entry at a time. The pointer wraps from 511 back to 0.

A separate read port serves the video pipeline. It returns the entry at a video-side index one clock after the index is presented, whatever the host is doing in the same cycle. The block also holds a small display-control register: a dot-clock divider, a blur enable and a grayscale enable. The block only stores these bits. Other logic acts on them.

Top module: `palette_port`

## Requirements
- R1: After reset the color pointer is 0 and dot_div, blur_en and gray_en are all 0.
- R2: A write to select 2 loads pointer bits 7:0 from data bits 7:0. A write to select 3 loads pointer bit 8 from data bit 0. Neither write changes the other pointer bits.
- R3: A write to select 4 stores data bits 7:0 into bits 7:0 of the entry at the pointer. Bit 8 of that entry and the pointer itself are left unchanged.
- R4: A write to select 5 stores data bit 0 into bit 8 of the entry at the pointer, and the pointer then advances by one.
- R5: A read at select 4 returns bits 7:0 of the entry at the pointer, combinationally, and leaves the pointer unchanged.
- R6: A read at select 5 returns bit 8 of the entry at the pointer on data bit 0, with bits 7:1 zero, and the pointer advances by one at the next clock edge.
- R7: A write to select 0 sets dot_div from data bits 1:0, blur_en from data bit 2 and gray_en from data bit 7. No other write changes these outputs.
- R8: A read at select 0, 1, 2, 3, 6 or 7 returns zero and has no side effect.
- R9: When the pointer is 511, an advance moves it to 0.
- R10: vid_color equals the entry at the vid_addr sampled at the previous clock edge. If a host write to that entry happens in the same cycle, vid_color shows the value before the write.
- R11: When host_wr and host_rd are both high, the write takes effect and the read causes no pointer advance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_sel | input | 3 | Register select |
| host_wr | input | 1 | Host write strobe, one cycle per access |
| host_rd | input | 1 | Host read strobe, one cycle per access |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Host read data, valid in the same cycle as the access |
| vid_addr | input | 9 | Video-side palette index |
| vid_color | output | 9 | Palette entry, one cycle after vid_addr |
| dot_div | output | 2 | Dot clock divider setting |
| blur_en | output | 1 | Blur enable |
| gray_en | output | 1 | Grayscale enable |

## Verification
The assertions assume that each host strobe lasts one cycle per intended access. They also assume that host_sel is a known value whenever a strobe is high. The bench drives every access as a single-cycle pulse and keeps the select and data at defined values while the strobes are low.

The random part of the stimulus draws selects from all eight codes, with both strobes in the mix. This includes cycles where read and write are high together, so the checks see collisions of pointer loads, advances and control writes. Directed sequences cover the pointer wrap, a write to the entry the video side is reading in the same cycle, and reads at unmapped selects.

// File: rtl/palette_port.sv
module palette_port #(
  parameter int ADDR_W = 9,
  parameter int DATA_W = 9,
  parameter int BUS_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        host_sel,
  input  logic              host_wr,
  input  logic              host_rd,
  input  logic [BUS_W-1:0]  host_wdata,
  output logic [BUS_W-1:0]  host_rdata,
  input  logic [ADDR_W-1:0] vid_addr,
  output logic [DATA_W-1:0] vid_color,
  output logic [1:0]        dot_div,
  output logic              blur_en,
  output logic              gray_en
);
  localparam int HI_A  = ADDR_W - BUS_W;
  localparam int HI_D  = DATA_W - BUS_W;
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] pal [DEPTH];
  logic [ADDR_W-1:0] caddr;

  wire wr_ctl  = host_wr && host_sel == 3'd0;
  wire wr_alo  = host_wr && host_sel == 3'd2;
  wire wr_ahi  = host_wr && host_sel == 3'd3;
  wire wr_lo   = host_wr && host_sel == 3'd4;
  wire wr_hi   = host_wr && host_sel == 3'd5;
  wire rd_hi   = host_rd && !host_wr && host_sel == 3'd5;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      caddr   <= '0;
      dot_div <= '0;
      blur_en <= 1'b0;
      gray_en <= 1'b0;
    end else begin
      if (wr_alo)
        caddr[BUS_W-1:0] <= host_wdata;
      else if (wr_ahi)
        caddr[ADDR_W-1:BUS_W] <= host_wdata[HI_A-1:0];
      else if (wr_hi || rd_hi)
        caddr <= caddr + ADDR_W'(1);
      if (wr_ctl) begin
        dot_div <= host_wdata[1:0];
        blur_en <= host_wdata[2];
        gray_en <= host_wdata[7];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (wr_lo) pal[caddr][BUS_W-1:0]      <= host_wdata;
    if (wr_hi) pal[caddr][DATA_W-1:BUS_W] <= host_wdata[HI_D-1:0];
    vid_color <= pal[vid_addr];
  end

  always_comb begin
    case (host_sel)
      3'd4:    host_rdata = pal[caddr][BUS_W-1:0];
      3'd5:    host_rdata = {{(BUS_W-HI_D){1'b0}}, pal[caddr][DATA_W-1:BUS_W]};
      default: host_rdata = '0;
    endcase
  end
endmodule

// File: rtl/palette_port_chk.sv
module palette_port_chk #(
  parameter int ADDR_W = 9,
  parameter int BUS_W  = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic [2:0]        host_sel,
  input logic              host_wr,
  input logic              host_rd,
  input logic [BUS_W-1:0]  host_rdata,
  input logic [ADDR_W-1:0] caddr,
  input logic [1:0]        dot_div,
  input logic              blur_en,
  input logic              gray_en
);
  logic [ADDR_W-1:0] nxt;
  assign nxt = caddr + ADDR_W'(1);

  AST_HI_WR_ADVANCES: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr && host_sel == 3'd5) |=> caddr == $past(nxt)); // R4

  AST_LO_WR_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr && host_sel == 3'd4) |=> $stable(caddr)); // R3

  AST_LO_RD_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (host_rd && !host_wr && host_sel == 3'd4) |=> $stable(caddr)); // R5

  AST_HI_RD_ADVANCES: assert property (@(posedge clk) disable iff (!rst_n)
    (host_rd && !host_wr && host_sel == 3'd5) |=> caddr == $past(nxt)); // R6

  AST_HI_RD_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (host_rd && host_sel == 3'd5) |-> host_rdata[BUS_W-1:1] == '0); // R6

  AST_UNMAPPED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (host_rd && !host_wr && (host_sel == 3'd1 || host_sel >= 3'd6))
      |-> host_rdata == '0); // R8

  AST_UNMAPPED_NO_MOVE: assert property (@(posedge clk) disable iff (!rst_n)
    (host_rd && !host_wr && host_sel != 3'd5) |=> $stable(caddr)); // R8

  AST_CTRL_ONLY_SEL0: assert property (@(posedge clk) disable iff (!rst_n)
    !(host_wr && host_sel == 3'd0) |=> $stable({dot_div, blur_en, gray_en})); // R7

  AST_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr && host_sel == 3'd5 && caddr == '1) |=> caddr == '0); // R9
endmodule

bind palette_port palette_port_chk #(.ADDR_W(ADDR_W), .BUS_W(BUS_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .host_sel(host_sel), .host_wr(host_wr),
  .host_rd(host_rd), .host_rdata(host_rdata), .caddr(caddr),
  .dot_div(dot_div), .blur_en(blur_en), .gray_en(gray_en)
);

// File: tb/test_palette_port.sv
`timescale 1ns/1ps
module test_palette_port;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] host_sel = '0;
  logic       host_wr = 1'b0, host_rd = 1'b0;
  logic [7:0] host_wdata = '0;
  logic [7:0] host_rdata;
  logic [8:0] vid_addr = '0;
  logic [8:0] vid_color;
  logic [1:0] dot_div;
  logic       blur_en, gray_en;

  int errors = 0, checks = 0;
  logic [8:0] m_pal [512];
  logic [8:0] m_ptr;
  logic [1:0] m_div;
  logic       m_blur, m_gray;
  logic [8:0] exp_vid;
  bit         vid_pending = 0;

  always #4 clk = ~clk;

  palette_port i_palette_port (
    .clk(clk), .rst_n(rst_n), .host_sel(host_sel), .host_wr(host_wr),
    .host_rd(host_rd), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .vid_addr(vid_addr), .vid_color(vid_color), .dot_div(dot_div),
    .blur_en(blur_en), .gray_en(gray_en)
  );

  function automatic logic [7:0] exp_rd(input logic [2:0] sel);
    if (sel == 3'd4) return m_pal[m_ptr][7:0];
    if (sel == 3'd5) return {7'b0, m_pal[m_ptr][8]};
    return 8'h00;
  endfunction

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] expv);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, expv);
    end
  endtask

  task automatic op(input bit wr, input bit rd, input logic [2:0] sel,
                    input logic [7:0] d, input logic [8:0] va);
    @(negedge clk);
    if (vid_pending) check("R10", {7'b0, vid_color}, {7'b0, exp_vid});
    host_wr = wr; host_rd = rd; host_sel = sel; host_wdata = d; vid_addr = va;
    #1;
    if (rd) begin
      if (sel == 3'd4 || sel == 3'd5) check(sel == 3'd4 ? "R5" : "R6", {8'b0, host_rdata}, {8'b0, exp_rd(sel)});
      else check("R8", {8'b0, host_rdata}, 16'h0);
    end
    exp_vid = m_pal[va];
    vid_pending = 1;
    @(posedge clk);
    #1;
    host_wr = 0; host_rd = 0;
    if (wr) begin
      case (sel)
        3'd0: begin m_div = d[1:0]; m_blur = d[2]; m_gray = d[7]; end
        3'd2: m_ptr[7:0] = d;
        3'd3: m_ptr[8] = d[0];
        3'd4: m_pal[m_ptr][7:0] = d;
        3'd5: begin m_pal[m_ptr][8] = d[0]; m_ptr = m_ptr + 9'd1; end
        default: ;
      endcase
    end else if (rd && sel == 3'd5) m_ptr = m_ptr + 9'd1;
    check("R7", {12'b0, m_div, m_blur, m_gray}, {12'b0, dot_div, blur_en, gray_en});
  endtask

  task automatic set_ptr(input logic [8:0] p);
    op(1, 0, 3'd2, p[7:0], '0);
    op(1, 0, 3'd3, {7'b0, p[8]}, '0);
  endtask

  initial begin
    #2000000;
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(1234));
    m_ptr = '0; m_div = '0; m_blur = 0; m_gray = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    check("R1", {12'b0, dot_div, blur_en, gray_en}, 16'h0);
    // fill whole palette from pointer 0; R1 pointer reset seen via fill order
    for (int i = 0; i < 512; i++) begin
      logic [8:0] w;
      w = 9'($urandom);
      op(1, 0, 3'd4, w[7:0], '0);
      op(1, 0, 3'd5, {7'b0, w[8]}, '0);
    end
    for (int i = 0; i < 512; i += 37) op(0, 0, 3'd1, 8'h00, 9'(i)); // R10 sweep
    set_ptr(9'd0);
    op(0, 1, 3'd4, 8'h00, '0); // R1/R3 fill order
    // R9 wrap
    set_ptr(9'd511);
    op(1, 0, 3'd4, 8'hA5, 9'd511);
    op(1, 0, 3'd5, 8'h01, 9'd511);
    op(0, 1, 3'd4, 8'h00, 9'd511);   // R9 reads entry 0
    op(0, 1, 3'd5, 8'h00, 9'd0);
    // R2 partial pointer loads
    set_ptr(9'h1F0);
    op(1, 0, 3'd2, 8'h22, '0);
    op(0, 1, 3'd4, 8'h00, '0);        // R2 entry 0x122
    op(1, 0, 3'd3, 8'hFE, '0);
    op(0, 1, 3'd4, 8'h00, '0);        // R2 entry 0x022
    // R10 same-cycle write to viewed entry
    op(1, 0, 3'd4, 8'h3C, 9'h022);
    op(0, 0, 3'd7, 8'h00, 9'h022);
    // R11 collision
    op(1, 1, 3'd4, 8'h77, '0);
    op(1, 1, 3'd5, 8'h00, '0);
    op(0, 1, 3'd4, 8'h00, '0);
    // R8 unmapped reads
    for (int s = 0; s < 8; s++) if (s != 4 && s != 5) op(0, 1, 3'(s), 8'h00, '0);
    op(0, 1, 3'd4, 8'h00, '0);
    // R7 control
    op(1, 0, 3'd0, 8'h87, '0);
    op(1, 0, 3'd0, 8'h7A, '0);
    // random mix
    for (int i = 0; i < 4000; i++) begin
      logic [2:0] s;
      bit w, r;
      s = 3'($urandom);
      w = ($urandom % 3) == 0;
      r = !w || ($urandom % 8) == 0;
      op(w, r, s, 8'($urandom), 9'($urandom));
    end
    @(negedge clk);
    check("R10", {7'b0, vid_color}, {7'b0, exp_vid});
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule